// File: doc/BRIEF.md
# Banked Program Status Register Unit

This block keeps a processor's 32-bit current status word together with a separate saved status word for each of the five exception modes. A move-to-status operation merges any chosen subset of the four byte fields from a 32-bit operand into either the current word or the active mode's saved word. A move-from-status operation captures either word into a registered read port. An exception-entry strobe copies the live status into the saved word of the target mode. In the same clock it switches the mode field and masks interrupts.

Write protection depends on the active mode. In user mode only the flag byte of the current word can be written. In user and system modes there is no saved word: saved-word reads fall back to the current word and saved-word writes are dropped. The condition-passed input gates reads and writes. It does not gate exception entry.

Top module: `psr_bank_unit`

## Requirements
- R1: Synchronous active-high reset sets the current word to 0x000000D3 (supervisor mode, I and F set, flags clear), clears every saved word, and clears the read data.
- R2: Mask bit 3 selects bits 31:24, bit 2 selects bits 23:16, bit 1 selects bits 15:8 and bit 0 selects bits 7:0. A current-word write in any non-user mode replaces exactly the selected bytes with the operand bytes. Every unselected bit keeps its value.
- R3: In user mode (10000), a current-word write changes only bits 31:24. Mask bits 2:0 are ignored there.
- R4: A saved-word write in a mode that has a saved word merges the selected bytes into that mode's saved word only. The current word and the other saved words are unchanged.
- R5: In user mode (10000) and system mode (11111), a saved-word read returns the current word, and a saved-word write changes nothing.
- R6: A read with rd_en and cond_ok high updates rd_data at that clock edge. rd_data then shows the value held before the edge, taken from the saved word when rd_saved is 1 and from the current word otherwise. Without such a read, rd_data holds.
- R7: With cond_ok low, writes and reads have no effect.
- R8: Exception entry into a mode with a saved word does the following in one clock, whatever the value of cond_ok. It copies the old current word into that mode's saved word. It sets bits 4:0 to the target code and sets bit 7 (I). It also sets bit 6 (F) when the target is 10001. All other current bits keep their values, and a write in the same cycle is discarded.
- R9: Saved words exist for exactly the codes 10001, 10010, 10011, 10111 and 11011. Exception entry with any other target code is ignored, and a write in the same cycle then proceeds as usual.
- R10: Bits 31:24, including the sticky Q flag at bit 27, change only through a flags-field write. Exception entry and writes to the other fields leave them intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_saved | input | 1 | Read source: 1 selects the saved word of the active mode, 0 selects the current word |
| wr_en | input | 1 | Write request |
| wr_saved | input | 1 | Write target: 1 selects the saved word, 0 selects the current word |
| field_mask | input | 4 | Byte-field select for writes |
| wr_data | input | 32 | Write operand |
| cond_ok | input | 1 | Condition-passed qualifier for reads and writes |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode code for exception entry |
| cur_psr | output | 32 | Current status word |
| rd_data | output | 32 | Registered read result |

## Verification
A wrong merge or a wrong protection decision on the current word shows on cur_psr at the very next edge. A wrongly banked or wrongly merged saved word stays hidden until a saved-word read is made in that mode, and then appears on rd_data one clock after the read. The sweeps therefore follow every write with reads of both sources. Each exception entry is followed by a saved-word read in the new mode, so a wrong bank choice appears within two cycles.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int PSR_W      = 32;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = PSR_W / FIELD_W;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = 3;
    localparam int MODE_W     = 5;

    localparam logic [BANK_IDX_W-1:0] NO_BANK = '1;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } psr_mode_e;

    localparam int BIT_I  = 7;
    localparam int BIT_F  = 6;
    localparam int FLAG_FIELD = NUM_FIELDS - 1;

    localparam logic [PSR_W-1:0] PSR_RESET = {{(PSR_W-8){1'b0}}, 3'b110, MODE_SVC};

    typedef struct packed {
        logic                  en;
        logic                  to_saved;
        logic [NUM_FIELDS-1:0] mask;
        logic [PSR_W-1:0]      data;
    } psr_wr_req_t;

    function automatic logic [BANK_IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: bank_of = 3'd0;
            MODE_IRQ: bank_of = 3'd1;
            MODE_SVC: bank_of = 3'd2;
            MODE_ABT: bank_of = 3'd3;
            MODE_UND: bank_of = 3'd4;
            default:  bank_of = NO_BANK;
        endcase
    endfunction

    function automatic logic is_priv(input logic [MODE_W-1:0] m);
        is_priv = (m != MODE_USR);
    endfunction

    function automatic logic [PSR_W-1:0] merge_fields(
        input logic [PSR_W-1:0]      old_v,
        input logic [PSR_W-1:0]      new_v,
        input logic [NUM_FIELDS-1:0] mask
    );
        logic [PSR_W-1:0] r;
        r = old_v;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (mask[f]) r[f*FIELD_W +: FIELD_W] = new_v[f*FIELD_W +: FIELD_W];
        end
        merge_fields = r;
    endfunction

endpackage

// File: rtl/psr_write_ctl.sv
module psr_write_ctl
    import psr_pkg::*;
(
    input  psr_wr_req_t                 wr_req,
    input  logic                        cond_ok,
    input  logic                        exc_enter,
    input  logic [MODE_W-1:0]           exc_mode,
    input  logic [MODE_W-1:0]           cur_mode,
    output logic                        exc_take,
    output logic [BANK_IDX_W-1:0]       exc_bank,
    output logic [BANK_IDX_W-1:0]       cur_bank,
    output logic [NUM_FIELDS-1:0]       cur_mask,
    output logic [NUM_FIELDS-1:0]       sav_mask
);
    logic wr_go;
    logic [NUM_FIELDS-1:0] user_limit;

    always_comb begin
        user_limit = '0;
        user_limit[FLAG_FIELD] = 1'b1;
        exc_bank = bank_of(exc_mode);
        cur_bank = bank_of(cur_mode);
        exc_take = exc_enter && (exc_bank != NO_BANK);
        wr_go    = wr_req.en && cond_ok && !exc_take;
        cur_mask = '0;
        sav_mask = '0;
        if (wr_go && !wr_req.to_saved)
            cur_mask = is_priv(cur_mode) ? wr_req.mask : (wr_req.mask & user_limit);
        if (wr_go && wr_req.to_saved && (cur_bank != NO_BANK))
            sav_mask = wr_req.mask;
    end
endmodule

// File: rtl/psr_cur_reg.sv
module psr_cur_reg
    import psr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  exc_take,
    input  logic [MODE_W-1:0]     exc_mode,
    input  logic [NUM_FIELDS-1:0] cur_mask,
    input  logic [PSR_W-1:0]      wr_data,
    output logic [PSR_W-1:0]      cur_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= PSR_RESET;
        end else if (exc_take) begin
            cur_q[MODE_W-1:0] <= exc_mode;
            cur_q[BIT_I]      <= 1'b1;
            if (exc_mode == MODE_FIQ) cur_q[BIT_F] <= 1'b1;
        end else begin
            cur_q <= merge_fields(cur_q, wr_data, cur_mask);
        end
    end

    // R1
    cur_reset_chk: assert property (@(posedge clk) rst |=> cur_q == PSR_RESET);

    // R8
    exc_load_chk: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (cur_q[MODE_W-1:0] == $past(exc_mode)) && cur_q[BIT_I]
                     && (cur_q[PSR_W-1:8] == $past(cur_q[PSR_W-1:8])));

    // R2
    ctrl_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!exc_take && cur_mask == 4'b0001) |=> cur_q[PSR_W-1:8] == $past(cur_q[PSR_W-1:8]));
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
    import psr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            exc_take,
    input  logic [BANK_IDX_W-1:0]           exc_bank,
    input  logic [BANK_IDX_W-1:0]           cur_bank,
    input  logic [NUM_FIELDS-1:0]           sav_mask,
    input  logic [PSR_W-1:0]                wr_data,
    input  logic [PSR_W-1:0]                cur_in,
    output logic [NUM_BANKS-1:0][PSR_W-1:0] sav_q
);
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam logic [BANK_IDX_W-1:0] KIDX = BANK_IDX_W'(k);

        always_ff @(posedge clk) begin
            if (rst)
                sav_q[k] <= '0;
            else if (exc_take && exc_bank == KIDX)
                sav_q[k] <= cur_in;
            else if (cur_bank == KIDX)
                sav_q[k] <= merge_fields(sav_q[k], wr_data, sav_mask);
        end

        // R8
        bank_copy_chk: assert property (@(posedge clk) disable iff (rst)
            (exc_take && exc_bank == KIDX) |=> sav_q[k] == $past(cur_in));

        // R4
        bank_isolate_chk: assert property (@(posedge clk) disable iff (rst)
            (!exc_take && cur_bank != KIDX) |=> $stable(sav_q[k]));
    end
endmodule

// File: rtl/psr_read_port.sv
module psr_read_port
    import psr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  logic                            rd_saved,
    input  logic                            cond_ok,
    input  logic [BANK_IDX_W-1:0]           cur_bank,
    input  logic [PSR_W-1:0]                cur_in,
    input  logic [NUM_BANKS-1:0][PSR_W-1:0] sav_in,
    output logic [PSR_W-1:0]                rd_q
);
    logic [PSR_W-1:0] pick;

    always_comb begin
        pick = cur_in;
        if (rd_saved) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                if (cur_bank == BANK_IDX_W'(k)) pick = sav_in[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  rd_q <= '0;
        else if (rd_en && cond_ok) rd_q <= pick;
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && cond_ok) |=> $stable(rd_q));

    // R5
    rd_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cond_ok && cur_bank == NO_BANK) |=> rd_q == $past(cur_in));
endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit
    import psr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic                  rd_saved,
    input  logic                  wr_en,
    input  logic                  wr_saved,
    input  logic [NUM_FIELDS-1:0] field_mask,
    input  logic [PSR_W-1:0]      wr_data,
    input  logic                  cond_ok,
    input  logic                  exc_enter,
    input  logic [MODE_W-1:0]     exc_mode,
    output logic [PSR_W-1:0]      cur_psr,
    output logic [PSR_W-1:0]      rd_data
);
    psr_wr_req_t                     wr_req;
    logic                            exc_take;
    logic [BANK_IDX_W-1:0]           exc_bank;
    logic [BANK_IDX_W-1:0]           cur_bank;
    logic [NUM_FIELDS-1:0]           cur_mask;
    logic [NUM_FIELDS-1:0]           sav_mask;
    logic [NUM_BANKS-1:0][PSR_W-1:0] sav_q;

    assign wr_req = '{en: wr_en, to_saved: wr_saved, mask: field_mask, data: wr_data};

    psr_write_ctl u_ctl (
        .wr_req    (wr_req),
        .cond_ok   (cond_ok),
        .exc_enter (exc_enter),
        .exc_mode  (exc_mode),
        .cur_mode  (cur_psr[MODE_W-1:0]),
        .exc_take  (exc_take),
        .exc_bank  (exc_bank),
        .cur_bank  (cur_bank),
        .cur_mask  (cur_mask),
        .sav_mask  (sav_mask)
    );

    psr_cur_reg u_cur (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_take),
        .exc_mode (exc_mode),
        .cur_mask (cur_mask),
        .wr_data  (wr_data),
        .cur_q    (cur_psr)
    );

    psr_saved_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_take),
        .exc_bank (exc_bank),
        .cur_bank (cur_bank),
        .sav_mask (sav_mask),
        .wr_data  (wr_data),
        .cur_in   (cur_psr),
        .sav_q    (sav_q)
    );

    psr_read_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_saved (rd_saved),
        .cond_ok  (cond_ok),
        .cur_bank (cur_bank),
        .cur_in   (cur_psr),
        .sav_in   (sav_q),
        .rd_q     (rd_data)
    );

    // R7
    cond_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!cond_ok && !exc_enter) |=> $stable(cur_psr));

    // R3
    user_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_psr[MODE_W-1:0] == MODE_USR && !exc_enter) |=> cur_psr[23:0] == $past(cur_psr[23:0]));

    // R10
    flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cond_ok && !wr_saved && field_mask[3]) |=> cur_psr[31:24] == $past(cur_psr[31:24]));
endmodule

// File: tb/sim_psr_bank_unit.sv
module sim_psr_bank_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, rd_en, rd_saved, wr_en, wr_saved, cond_ok, exc_enter;
    logic [3:0]  field_mask;
    logic [31:0] wr_data;
    logic [4:0]  exc_mode;
    logic [31:0] cur_psr, rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_cur;
    logic [31:0] m_sav [5];
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_bank_unit u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_saved(rd_saved),
        .wr_en(wr_en), .wr_saved(wr_saved), .field_mask(field_mask),
        .wr_data(wr_data), .cond_ok(cond_ok), .exc_enter(exc_enter),
        .exc_mode(exc_mode), .cur_psr(cur_psr), .rd_data(rd_data)
    );

    function automatic int mbank(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] mmerge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] mk);
        logic [31:0] r = o;
        for (int f = 0; f < 4; f++) if (mk[f]) r[f*8 +: 8] = d[f*8 +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; rd_saved = 0; wr_en = 0; wr_saved = 0; field_mask = 0;
        wr_data = 0; cond_ok = 0; exc_enter = 0; exc_mode = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_write(input bit sv, input logic [3:0] mk, input logic [31:0] d);
        int b;
        b = mbank(m_cur[4:0]);
        if (!sv) m_cur = mmerge(m_cur, d, (m_cur[4:0] == 5'b10000) ? (mk & 4'b1000) : mk);
        else if (b >= 0) m_sav[b] = mmerge(m_sav[b], d, mk);
    endtask

    task automatic do_write(input string req, input bit sv, input logic [3:0] mk,
                            input logic [31:0] d, input bit c);
        idle();
        wr_en = 1; wr_saved = sv; field_mask = mk; wr_data = d; cond_ok = c;
        step();
        idle();
        if (c) model_write(sv, mk, d);
        check(req, cur_psr, m_cur);
    endtask

    task automatic do_read(input string req, input bit sv, input bit c);
        int b;
        idle();
        rd_en = 1; rd_saved = sv; cond_ok = c;
        step();
        idle();
        b = mbank(m_cur[4:0]);
        if (c) m_rd = (sv && b >= 0) ? m_sav[b] : m_cur;
        check(req, rd_data, m_rd);
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        step();
        rst = 0;
        m_cur = 32'h0000_00D3;
        for (int i = 0; i < 5; i++) m_sav[i] = 0;
        m_rd = 0;
    endtask

    task automatic go_mode(input logic [4:0] m);
        do_reset();
        do_write("R2 mode set", 0, 4'b0001, {24'h0, 3'b110, m}, 1);
    endtask

    logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00101};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        do_reset();
        // R1: reset values at the ports and in the saved words
        check("R1 cur", cur_psr, 32'h0000_00D3);
        check("R1 rd", rd_data, 32'h0);
        do_read("R1 saved svc", 1, 1);

        // R2 R3 R4 R5 R6 R7: write sweep over modes, masks and targets
        for (int mi = 0; mi < 7; mi++) begin
            for (int mk = 0; mk < 16; mk++) begin
                for (int sv = 0; sv < 2; sv++) begin
                    logic [31:0] d;
                    d = {8'hF0 ^ {4'(mk), 4'(mk)}, 8'h5A + 8'(mk), 8'hC3 ^ 8'(mk), 8'h2C ^ 8'(sv * 16 + mk)};
                    go_mode(modes[mi]);
                    do_write("R7 write gated", sv[0], 4'(mk), ~d, 0);
                    do_write(sv ? "R4 R5 saved write" : "R2 R3 cur write", sv[0], 4'(mk), d, 1);
                    do_read("R6 R5 read saved", 1, 1);
                    do_read("R7 read gated", 0, 0);
                    do_read("R6 read cur", 0, 1);
                end
            end
        end

        // R8 R9 R10: exception entry from every mode to every target
        for (int si = 0; si < 7; si++) begin
            for (int ti = 0; ti < 8; ti++) begin
                int b;
                bit c;
                go_mode(modes[si]);
                do_write("R10 flags set", 0, 4'b1000, 32'h9C00_0000 | (32'(ti) << 24), 1);
                c = (ti % 2 == 0);
                idle();
                exc_enter = 1; exc_mode = modes[ti];
                wr_en = 1; wr_saved = 0; field_mask = 4'b1111; wr_data = 32'h0F0F_0F0F; cond_ok = c;
                step();
                idle();
                b = mbank(modes[ti]);
                if (b >= 0) begin
                    m_sav[b] = m_cur;
                    m_cur[4:0] = modes[ti];
                    m_cur[7] = 1'b1;
                    if (modes[ti] == 5'b10001) m_cur[6] = 1'b1;
                    check("R8 R10 exc cur", cur_psr, m_cur);
                end else begin
                    if (c) model_write(0, 4'b1111, 32'h0F0F_0F0F);
                    check("R9 exc ignored", cur_psr, m_cur);
                end
                do_read("R8 R9 saved after exc", 1, 1);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule